// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 8192 words by 8 bits. The RAM has two chip enables, one active low and one active high, an active-low output enable, an active-low write enable and one bidirectional data bus. The host issues single-cycle requests with a valid/ready handshake. Each request carries a write flag, a 13-bit address and, for writes, a data byte. The controller expands each request into a strobe sequence whose phases are long enough for the RAM's nanosecond limits.

Each limit is a nanosecond parameter. At elaboration it is converted to a cycle count by a ceiling division by the clock-period parameter, and a zero limit stays zero. Reads drive both chip enables and the output enable. The returned byte is registered and flagged to the host with a one-cycle pulse. Writes use write-enable control and keep the output enable high throughout. The data driver is held off until the bus has had time to float after the most recent read, and the write pulse is stretched so that the data setup time is met before the write enable rises.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, both chip enables, the output enable and the write enable are inactive (ce1_n=1, ce2=0, oe_n=1, we_n=1), the data driver is off, rsp_valid is 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from that edge until the sequence completes, and a request presented while req_ready is 0 is not taken.
- R3: A read holds ce1_n=0, ce2=1, oe_n=0 and we_n=1 for RD cycles starting at the accept edge, where RD is the largest of the read-cycle, address-to-data and output-enable-to-data counts (at least 1). The data driver stays off during a read.
- R4: At the edge that ends a read, the bus byte is registered. rsp_valid is 1 for exactly the next cycle, and rsp_rdata holds the byte last written to that address.
- R5: During a write, oe_n stays 1, and we_n is 0 only while ce1_n=0 and ce2=1.
- R6: we_n stays low for at least the larger of the write-pulse and address-setup counts. The data driver is on with the write byte for at least the data-setup count (at least 1) before we_n rises, and it stays on with the chip enabled for at least the hold count (at least 1) after we_n rises.
- R7: The data driver turns on no earlier than HZ cycles after oe_n rises, where HZ is the converted output-enable-to-high-Z limit.
- R8: mem_addr changes only at an accept edge and is stable until the next accept.
- R9: A write sequence lasts at least the write-cycle count, measured from its accept edge to the edge that releases the chip enables.
- R10: Each count equals ceiling(t_ns / CLK_PERIOD_NS), and a zero limit gives zero cycles. With a 20 ns clock, a 50 ns output-enable release gives HZ=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse, read byte valid |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 13 | RAM address |
| mem_ce1_n | output | 1 | RAM chip enable, active low |
| mem_ce2 | output | 1 | RAM chip enable, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dout | output | 8 | Byte to drive onto the RAM bus |
| mem_dout_en | output | 1 | Enable for the controller's bus driver |
| mem_din | input | 8 | Byte read from the RAM bus |

## Verification
The bench overrides the output-enable release limit to 50 ns, so a write that follows a read waits three cycles before its driver turns on. Every other count is one cycle. For each accepted request, the reference model computes from the requirements the edge at which each strobe rises and falls: the read end at accept+RD, the driver start at the later of the accept edge and read end+HZ, the write-enable rise and the chip-enable release. Outputs are sampled on the falling clock edge, so a value registered at edge n is compared in the half-cycle after n. A request is presented again while the controller is busy, which tests that it is refused.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_READ   = 2'd1,
        PH_WPULSE = 2'd2,
        PH_WHOLD  = 2'd3
    } phase_e;

    // ceiling conversion of a nanosecond limit into clock cycles
    function automatic int ns_to_cyc(input int t_ns, input int period_ns);
        if (t_ns <= 0) return 0;
        return (t_ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_tat.sv
// Bus turnaround timer: counts down after the output enable is released.
module asram_tat #(
    parameter int HZ_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic read_done,
    output logic drive_ok
);
    localparam int TW = (HZ_CYC > 0) ? $clog2(HZ_CYC + 1) : 1;

    logic [TW-1:0] tat_d, tat_q;

    always_comb begin
        tat_d = tat_q;
        if (read_done) begin
            tat_d = TW'(HZ_CYC);
        end else if (tat_q != '0) begin
            tat_d = tat_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tat_q <= '0;
        else        tat_q <= tat_d;
    end

    // driving may start once HZ_CYC edges have passed since release
    assign drive_ok = (int'(tat_q) <= 1);

endmodule

// File: rtl/asram_seq.sv
// Strobe sequencer for read and write-enable-controlled write cycles.
module asram_seq
    import asram_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int RD_WAIT  = 1,
    parameter int PW_MIN   = 1,
    parameter int SD_MIN   = 1,
    parameter int HOLD_CYC = 1,
    parameter int WC_MIN   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              drive_ok,
    input  logic [DATA_W-1:0] mem_din,
    output logic              req_ready,
    output logic              read_done,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en
);
    localparam int CNT_MAX = RD_WAIT + PW_MIN + SD_MIN + HOLD_CYC + WC_MIN;
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        phase_e            ph;
        logic [CW-1:0]     cnt;    // phase cycle counter
        logic [CW-1:0]     sd;     // cycles data has been driven
        logic [CW-1:0]     tot;    // cycles since a write was taken
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              ce;
        logic              oe;
        logic              we;
        logic              drv;
    } seq_t;

    seq_t d, q;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v == {CW{1'b1}}) ? v : v + 1'b1;
    endfunction

    always_comb begin
        d         = q;
        d.rvalid  = 1'b0;
        read_done = 1'b0;
        unique case (q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    d.cnt  = '0;
                    d.sd   = '0;
                    d.tot  = '0;
                    d.ce   = 1'b1;
                    if (req_write) begin
                        d.ph    = PH_WPULSE;
                        d.we    = 1'b1;
                        d.oe    = 1'b0;
                        d.wdata = req_wdata;
                        d.drv   = drive_ok;
                    end else begin
                        d.ph = PH_READ;
                        d.oe = 1'b1;
                    end
                end
            end
            PH_READ: begin
                if (int'(q.cnt) + 1 >= RD_WAIT) begin
                    d.rdata   = mem_din;
                    d.rvalid  = 1'b1;
                    d.ce      = 1'b0;
                    d.oe      = 1'b0;
                    d.ph      = PH_IDLE;
                    read_done = 1'b1;
                end else begin
                    d.cnt = sat_inc(q.cnt);
                end
            end
            PH_WPULSE: begin
                d.tot = sat_inc(q.tot);
                if ((int'(q.cnt) + 1 >= PW_MIN) && q.drv &&
                    (int'(q.sd) + 1 >= SD_MIN)) begin
                    d.we  = 1'b0;
                    d.cnt = '0;
                    d.ph  = PH_WHOLD;
                end else begin
                    d.cnt = sat_inc(q.cnt);
                    d.sd  = q.drv ? sat_inc(q.sd) : '0;
                    d.drv = q.drv | drive_ok;
                end
            end
            PH_WHOLD: begin
                if ((int'(q.cnt) + 1 >= HOLD_CYC) && (int'(q.tot) + 1 >= WC_MIN)) begin
                    d.ce  = 1'b0;
                    d.drv = 1'b0;
                    d.ph  = PH_IDLE;
                end else begin
                    d.cnt = sat_inc(q.cnt);
                    d.tot = sat_inc(q.tot);
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready   = (q.ph == PH_IDLE);
    assign rsp_valid   = q.rvalid;
    assign rsp_rdata   = q.rdata;
    assign mem_addr    = q.addr;
    assign mem_ce1_n   = ~q.ce;
    assign mem_ce2     = q.ce;
    assign mem_oe_n    = ~q.oe;
    assign mem_we_n    = ~q.we;
    assign mem_dout    = q.wdata;
    assign mem_dout_en = q.drv;

endmodule

// File: rtl/asram_ctrl.sv
// Top: converts nanosecond limits to cycle counts and wires the sequencer.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_RC_NS       = 15,
    parameter int T_AA_NS       = 15,
    parameter int T_DOE_NS      = 8,
    parameter int T_WC_NS       = 15,
    parameter int T_PWE_NS      = 12,
    parameter int T_AW_NS       = 12,
    parameter int T_SD_NS       = 8,
    parameter int T_HD_NS       = 0,
    parameter int T_HZOE_NS     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int C_RC  = ns_to_cyc(T_RC_NS,   CLK_PERIOD_NS);
    localparam int C_AA  = ns_to_cyc(T_AA_NS,   CLK_PERIOD_NS);
    localparam int C_DOE = ns_to_cyc(T_DOE_NS,  CLK_PERIOD_NS);
    localparam int C_WC  = ns_to_cyc(T_WC_NS,   CLK_PERIOD_NS);
    localparam int C_PWE = ns_to_cyc(T_PWE_NS,  CLK_PERIOD_NS);
    localparam int C_AW  = ns_to_cyc(T_AW_NS,   CLK_PERIOD_NS);
    localparam int C_SD  = ns_to_cyc(T_SD_NS,   CLK_PERIOD_NS);
    localparam int C_HD  = ns_to_cyc(T_HD_NS,   CLK_PERIOD_NS);
    localparam int C_HZ  = ns_to_cyc(T_HZOE_NS, CLK_PERIOD_NS);

    localparam int RD_WAIT  = imax(imax(C_RC, C_AA), imax(C_DOE, 1));
    localparam int PW_MIN   = imax(imax(C_PWE, C_AW), 1);
    localparam int SD_MIN   = imax(C_SD, 1);
    localparam int HOLD_CYC = imax(C_HD, 1);

    logic read_done;
    logic drive_ok;

    asram_tat #(
        .HZ_CYC (C_HZ)
    ) u_tat (
        .clk       (clk),
        .rst_n     (rst_n),
        .read_done (read_done),
        .drive_ok  (drive_ok)
    );

    asram_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RD_WAIT  (RD_WAIT),
        .PW_MIN   (PW_MIN),
        .SD_MIN   (SD_MIN),
        .HOLD_CYC (HOLD_CYC),
        .WC_MIN   (C_WC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .drive_ok    (drive_ok),
        .mem_din     (mem_din),
        .req_ready   (req_ready),
        .read_done   (read_done),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .mem_addr    (mem_addr),
        .mem_ce1_n   (mem_ce1_n),
        .mem_ce2     (mem_ce2),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_dout    (mem_dout),
        .mem_dout_en (mem_dout_en)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_HZOE_NS     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en
);
    localparam int HZ_CYC = ns_to_cyc(T_HZOE_NS, CLK_PERIOD_NS);
    localparam int GW     = $clog2(HZ_CYC + 2) + 1;

    // edges elapsed since the output enable was last active, saturating
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  gap_q <= {GW{1'b1}};
        else if (!mem_oe_n)          gap_q <= '0;
        else if (gap_q != {GW{1'b1}}) gap_q <= gap_q + 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && mem_we_n && mem_oe_n && !mem_dout_en)); // R2
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dout_en && mem_we_n && !mem_ce1_n && mem_ce2)); // R3
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4
    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_oe_n)); // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dout_en && !mem_ce1_n && $stable(mem_dout))); // R6
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dout_en) |-> (int'(gap_q) >= HZ_CYC)); // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(mem_addr)); // R8

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_HZOE_NS     (T_HZOE_NS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .mem_addr    (mem_addr),
    .mem_ce1_n   (mem_ce1_n),
    .mem_ce2     (mem_ce2),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

    // expected counts at a 20 ns clock with the bench's parameter set
    localparam int RDC = 1;   // max(ceil(15/20), ceil(15/20), ceil(8/20))
    localparam int PWC = 1;   // max(ceil(12/20), ceil(12/20))
    localparam int SDC = 1;   // ceil(8/20)
    localparam int HDC = 1;   // hold 0 ns, minimum one cycle
    localparam int WCC = 1;   // ceil(15/20)
    localparam int HZC = 3;   // R10: ceil(50/20) = 3

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [12:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dout_en;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din;

    always #10 clk = ~clk;

    asram_ctrl #(.T_HZOE_NS(50)) i_asram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    // small RAM model, indexed by a 6-bit fold of the address
    function automatic logic [5:0] fold(input logic [12:0] a);
        return {a[12:10], a[2:0]};
    endfunction

    logic [7:0] dev_mem [64];
    logic [7:0] ref_mem [64];

    always_comb begin
        if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) mem_din = dev_mem[fold(mem_addr)];
        else                                                mem_din = 8'h00;
    end

    always @(posedge mem_we_n) begin
        if (!mem_ce1_n && mem_ce2 && mem_dout_en) dev_mem[fold(mem_addr)] = mem_dout;
    end

    int cyc = 0;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input logic [31:0] got, input logic [31:0] exp,
                       input string tag, input string name);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, name, cyc, got, exp);
        end
    endtask

    typedef struct {
        bit          w;
        logic [12:0] a;
        logic [7:0]  d;
        int          gap;
    } req_t;
    req_t rq[$];

    // reference model state, in accept-edge timestamps
    bit          op_act = 0;
    bit          op_w   = 0;
    int          op_k, op_r, op_a, op_wend, op_h, op_end;
    logic [12:0] op_addr = '0;
    logic [7:0]  op_data, op_rexp;
    int          last_rd = -100;

    task automatic model_step(input int n, input bit accepted, input req_t r);
        bit e_ce, e_oe, e_we, e_drv, e_rv, e_rdy;
        string tg;
        if (accepted) begin
            op_act  = 1;
            op_w    = r.w;
            op_k    = n;
            op_addr = r.a;
            op_data = r.d;
            if (!r.w) begin
                op_r    = n + RDC;
                op_end  = op_r;
                last_rd = op_r;
                op_rexp = ref_mem[fold(r.a)];
            end else begin
                op_a    = (n > last_rd + HZC) ? n : last_rd + HZC;
                op_wend = (n + PWC > op_a + SDC) ? n + PWC : op_a + SDC;
                op_h    = (op_wend + HDC > n + WCC) ? op_wend + HDC : n + WCC;
                op_end  = op_h;
                ref_mem[fold(r.a)] = r.d;
            end
        end
        e_rdy = !op_act || (n >= op_end);
        e_ce = 0; e_oe = 0; e_we = 0; e_drv = 0; e_rv = 0;
        if (op_act && !op_w) begin
            e_ce = (n < op_r);
            e_oe = e_ce;
            e_rv = (n == op_r);
        end else if (op_act) begin
            e_ce  = (n < op_h);
            e_we  = (n < op_wend);
            e_drv = (n >= op_a) && (n < op_h);
        end
        tg = op_w ? "R9" : "R2";
        chk(req_ready, e_rdy, tg, "req_ready");
        tg = op_w ? "R5" : "R3";
        chk(mem_ce1_n, !e_ce, tg, "mem_ce1_n");
        chk(mem_ce2, e_ce, tg, "mem_ce2");
        chk(mem_oe_n, !e_oe, tg, "mem_oe_n");
        chk(mem_we_n, !e_we, "R6", "mem_we_n");
        tg = (op_w && n < last_rd + HZC) ? "R7" : "R6";
        chk(mem_dout_en, e_drv, tg, "mem_dout_en");
        if (e_drv) chk(mem_dout, op_data, "R6", "mem_dout");
        chk(mem_addr, op_addr, "R8", "mem_addr");
        chk(rsp_valid, e_rv, "R4", "rsp_valid");
        if (e_rv) chk(rsp_rdata, op_rexp, "R4", "rsp_rdata");
    endtask

    function automatic req_t mk(input bit w, input logic [12:0] a,
                                input logic [7:0] d, input int gap);
        req_t r;
        r.w = w; r.a = a; r.d = d; r.gap = gap;
        return r;
    endfunction

    initial begin
        bit    vld_prev;
        bit    rdy_prev;
        int    gap_left;
        int    guard;
        req_t  head;
        for (int i = 0; i < 64; i++) begin
            dev_mem[i] = 8'(i * 7 + 1);
            ref_mem[i] = 8'(i * 7 + 1);
        end
        rq.push_back(mk(0, 13'h00A5, 8'h00, 0)); // unwritten location
        rq.push_back(mk(1, 13'h00A5, 8'h3C, 0)); // write right after read: turnaround
        rq.push_back(mk(0, 13'h00A5, 8'h00, 0));
        rq.push_back(mk(1, 13'h1FFF, 8'hFF, 5)); // no recent read
        rq.push_back(mk(1, 13'h0000, 8'h00, 0)); // back-to-back writes
        rq.push_back(mk(0, 13'h1FFF, 8'h00, 0));
        rq.push_back(mk(0, 13'h0000, 8'h00, 0));
        rq.push_back(mk(1, 13'h1234, 8'hA5, 1)); // partly elapsed turnaround
        rq.push_back(mk(0, 13'h1234, 8'h00, 3));
        rq.push_back(mk(1, 13'h0C03, 8'h5A, 0));
        rq.push_back(mk(0, 13'h0C03, 8'h00, 0));
        rq.push_back(mk(0, 13'h0806, 8'h00, 2));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mem_ce1_n, 1'b1, "R1", "mem_ce1_n");
        chk(mem_ce2, 1'b0, "R1", "mem_ce2");
        chk(mem_oe_n, 1'b1, "R1", "mem_oe_n");
        chk(mem_we_n, 1'b1, "R1", "mem_we_n");
        chk(mem_dout_en, 1'b0, "R1", "mem_dout_en");
        chk(req_ready, 1'b1, "R1", "req_ready");
        chk(rsp_valid, 1'b0, "R1", "rsp_valid");
        rst_n = 1'b1;

        vld_prev = 0;
        rdy_prev = 1;
        gap_left = rq[0].gap;
        guard    = 0;
        head     = rq[0];
        while ((rq.size() > 0 || req_valid || cyc < op_end + 2) && guard < 3000) begin
            bit acc;
            @(negedge clk);
            guard++;
            acc = vld_prev && rdy_prev;
            if (acc) begin
                head = rq.pop_front();
                gap_left = (rq.size() > 0) ? rq[0].gap : 0;
            end
            model_step(cyc, acc, head);
            rdy_prev = !op_act || (cyc >= op_end);
            if (req_valid && !acc) begin
                // held while busy: must not be taken (R2)
            end else begin
                req_valid = 1'b0;
                if (gap_left > 0) begin
                    gap_left--;
                end else if (rq.size() > 0) begin
                    req_valid = 1'b1;
                    req_write = rq[0].w;
                    req_addr  = rq[0].a;
                    req_wdata = rq[0].d;
                end
            end
            vld_prev = req_valid;
        end
        if (guard >= 3000) begin
            vectors++;
            miscompares++;
            $display("FAIL R2 watchdog: actual %0d requests left, expected 0", rq.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule